// File: doc/BRIEF.md
# Byte-Mask Flow Tag CRC Generator

The block derives a 32-bit flow tag for each packet. Packet bytes arrive one per cycle with start and end markers. A programmable byte mask decides which byte offsets take part in the tag, and only those bytes are folded into a CRC-32 engine. When the last byte has been accepted, the finished CRC is presented as the tag for one cycle. Downstream logic can use the tag to group packets of the same flow.

There are four masks. Each mask covers the first 128 byte offsets of a packet and is held as sixteen 8-bit enable registers. Software loads the registers through a small write port that can replace a register, OR bits into it, or zero a whole mask at once. Two interfaces each keep their own CRC configuration: an initial value, a reflect control and an output inversion control. At the start of a packet the packet chooses its mask and its interface, and it can turn hashing off entirely.

Top module: `flowtag_crc_unit`

## Requirements
- R1: Mask register index is {mask number, 4-bit register slot}, a 6-bit value. Byte offset X of a packet using mask m is selected when bit (7 - X mod 8) of register m*16 + X/8 is 1, so bit 7 of each register is the lowest offset it covers. The mask number is taken from `pkt_mask_sel` in the start cycle and holds for the whole packet.
- R2: A register write with `mreg_or`=0 replaces the register with `mreg_wdata`. A write with `mreg_or`=1 ORs `mreg_wdata` into the register and leaves its other bits unchanged.
- R3: A pulse on `mask_clr` zeroes all sixteen registers of mask `mask_clr_sel`. A packet that then uses that mask hashes no bytes.
- R4: Offsets of 128 and above are never hashed. A packet shorter than its enabled range hashes only the bytes it actually carries.
- R5: When `pkt_tag_en` is 0 in the start cycle, no byte of that packet is hashed, whatever the mask holds, and the tag equals the initial value XOR the inversion mask.
- R6: With reflect off, each selected byte is shifted MSB first into a CRC-32 with polynomial 0x04C11DB7, starting from the interface's 32-bit initial value.
- R7: With reflect on, the result equals the bit-reflected CRC-32: the initial value is loaded bit-reversed, each byte is bit-reversed before it enters, and the result is bit-reversed, so a packet with no selected bytes still yields the initial value. With initial value 0xFFFFFFFF, reflect on and invert on, the ASCII bytes "123456789" give 0xCBF43926.
- R8: With invert on, the tag is the bitwise complement of the CRC result.
- R9: `tag_valid` is 1 for exactly one cycle, the cycle after the end byte is accepted, and `tag` carries the result in that cycle. `tag_valid` is 0 in and after reset until a packet ends.
- R10: A byte is accepted only when `pkt_valid` is 1, and either `pkt_sop` is 1 or a packet is open. A start byte always opens a new packet, discarding an unfinished one, and a byte carrying both markers is a one-byte packet. Bytes with `pkt_valid` 0 are skipped, and a stray byte outside a packet, including a stray end marker, has no effect.
- R11: Each interface has its own configuration. It resets to initial value 0xFFFFFFFF with reflect on and invert on, and is rewritten by `crc_we`. The interface is chosen by `pkt_if` in the start cycle, and its configuration is captured then, so a configuration write during a packet does not affect that packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mreg_we | input | 1 | Mask register write strobe |
| mreg_idx | input | 6 | Mask register index {mask, slot} |
| mreg_wdata | input | 8 | Mask register write data |
| mreg_or | input | 1 | 1: OR data into register, 0: replace |
| mask_clr | input | 1 | Zero every register of one mask |
| mask_clr_sel | input | 2 | Mask to zero |
| crc_we | input | 1 | CRC configuration write strobe |
| crc_we_if | input | 1 | Interface whose configuration is written |
| crc_iv | input | 32 | Initial value to store |
| crc_reflect | input | 1 | Reflect control to store |
| crc_invert | input | 1 | Invert control to store |
| pkt_valid | input | 1 | Byte present this cycle |
| pkt_sop | input | 1 | First byte of packet |
| pkt_eop | input | 1 | Last byte of packet |
| pkt_data | input | 8 | Packet byte |
| pkt_mask_sel | input | 2 | Mask used by the packet (start cycle) |
| pkt_if | input | 1 | Interface of the packet (start cycle) |
| pkt_tag_en | input | 1 | Hashing enabled for the packet (start cycle) |
| tag_valid | output | 1 | Tag present, one cycle |
| tag | output | 32 | Flow tag |

## Verification
The nine-byte ASCII check string, run through a two-register mask in reflect-and-invert mode, pins the polynomial, the reflection and the inversion against a known constant. Other patterns separate the remaining cases. Single-bit masks at offsets 0, 7 and 9 show that bit order is MSB first. A 200-byte packet under a full mask shows that offsets past 127 are cut off, and a 5-byte packet shows that missing bytes are not counted. Cleared masks and hashing switched off both reduce the tag to the initial value XOR the inversion mask. Gapped, back-to-back, one-byte, aborted and stray-byte streams, and a configuration write during a packet, test the framing and the capture of settings at the start byte.

// File: rtl/flowtag_pkg.sv
package flowtag_pkg;

    localparam int          CRC_W    = 32;
    localparam logic [31:0] CRC_POLY = 32'h04C1_1DB7;

    typedef struct packed {
        logic [CRC_W-1:0] iv;
        logic             reflect;
        logic             invert;
    } crc_cfg_t;

    function automatic logic [7:0] rev8(input logic [7:0] v);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = v[7-i];
        return r;
    endfunction

    function automatic logic [CRC_W-1:0] rev32(input logic [CRC_W-1:0] v);
        logic [CRC_W-1:0] r;
        for (int i = 0; i < CRC_W; i++) r[i] = v[CRC_W-1-i];
        return r;
    endfunction

    // One byte, MSB first, unrolled over eight bit steps.
    function automatic logic [CRC_W-1:0] crc_byte(input logic [CRC_W-1:0] s,
                                                  input logic [7:0] b);
        logic [CRC_W-1:0] c;
        c = s ^ {b, {(CRC_W-8){1'b0}}};
        for (int k = 0; k < 8; k++)
            c = c[CRC_W-1] ? ((c << 1) ^ CRC_POLY) : (c << 1);
        return c;
    endfunction

endpackage

// File: rtl/ftag_mask_bank.sv
module ftag_mask_bank #(
    parameter int NUM_MASKS     = 4,
    parameter int REGS_PER_MASK = 16
) (
    input  logic                                      clk,
    input  logic                                      rst_n,
    input  logic                                      wr_en,
    input  logic [$clog2(NUM_MASKS*REGS_PER_MASK)-1:0] wr_idx,
    input  logic [7:0]                                wr_data,
    input  logic                                      wr_or,
    input  logic                                      clr_en,
    input  logic [$clog2(NUM_MASKS)-1:0]              clr_sel,
    input  logic [$clog2(NUM_MASKS)-1:0]              lk_sel,
    input  logic [$clog2(REGS_PER_MASK)+2:0]          lk_off,
    output logic                                      lk_bit
);

    localparam int NREG   = NUM_MASKS * REGS_PER_MASK;
    localparam int IDX_W  = $clog2(NREG);
    localparam int SEL_W  = $clog2(NUM_MASKS);
    localparam int SLOT_W = $clog2(REGS_PER_MASK);
    localparam int OFF_W  = SLOT_W + 3;

    logic [7:0] regs_q [NREG];
    logic [7:0] regs_d [NREG];

    always_comb begin
        for (int i = 0; i < NREG; i++) begin
            regs_d[i] = regs_q[i];
            if (clr_en && ((i / REGS_PER_MASK) == int'(clr_sel)))
                regs_d[i] = 8'h00;
            if (wr_en && (i == int'(wr_idx)))
                regs_d[i] = wr_or ? (regs_d[i] | wr_data) : wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) regs_q[i] <= 8'h00;
        end else begin
            regs_q <= regs_d;
        end
    end

    // Register slot from the upper offset bits; bit 7 is the lowest offset.
    logic [IDX_W-1:0] lk_idx;
    assign lk_idx = {lk_sel, lk_off[OFF_W-1:3]};
    assign lk_bit = regs_q[lk_idx][~lk_off[2:0]];

    // R3: the first slot of a cleared mask reads zero afterwards.
    a_r3_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && !wr_en) |=> (regs_q[{$past(clr_sel), {SLOT_W{1'b0}}}] == 8'h00));

    // R2: an OR write keeps every bit that was already set.
    a_r2_or_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_or && !clr_en) |=>
        ((regs_q[$past(wr_idx)] & $past(regs_q[wr_idx])) == $past(regs_q[wr_idx])));

endmodule

// File: rtl/ftag_crc_cfg.sv
module ftag_crc_cfg
    import flowtag_pkg::*;
#(
    parameter int NUM_IFS = 2,
    parameter int IF_W    = (NUM_IFS > 1) ? $clog2(NUM_IFS) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [IF_W-1:0] wr_if,
    input  crc_cfg_t        wr_cfg,
    input  logic [IF_W-1:0] rd_if,
    output crc_cfg_t        rd_cfg
);

    localparam crc_cfg_t CFG_RESET = '{iv: '1, reflect: 1'b1, invert: 1'b1};

    crc_cfg_t cfg_q [NUM_IFS];
    crc_cfg_t cfg_d [NUM_IFS];

    always_comb begin
        for (int i = 0; i < NUM_IFS; i++) begin
            cfg_d[i] = cfg_q[i];
            if (wr_en && (i == int'(wr_if))) cfg_d[i] = wr_cfg;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_IFS; i++) cfg_q[i] <= CFG_RESET;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign rd_cfg = cfg_q[rd_if];

    // R11: a written configuration is held for its interface.
    a_r11_cfg_store: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (cfg_q[$past(wr_if)] == $past(wr_cfg)));

endmodule

// File: rtl/ftag_crc_core.sv
module ftag_crc_core
    import flowtag_pkg::*;
#(
    parameter int SEL_W = 2,
    parameter int OFF_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pkt_valid,
    input  logic             pkt_sop,
    input  logic             pkt_eop,
    input  logic [7:0]       pkt_data,
    input  logic [SEL_W-1:0] pkt_mask_sel,
    input  logic             pkt_tag_en,
    input  crc_cfg_t         cfg_in,
    output logic [SEL_W-1:0] lk_sel,
    output logic [OFF_W-1:0] lk_off,
    input  logic             lk_bit,
    output logic             tag_valid,
    output logic [CRC_W-1:0] tag
);

    // The top bit of the offset counter marks "past the mask window".
    localparam int CNT_W = OFF_W + 1;

    typedef struct packed {
        logic             active;
        logic             en;
        logic [SEL_W-1:0] msel;
        logic [CNT_W-1:0] off;
        logic             reflect;
        logic             invert;
        logic [CRC_W-1:0] crc;
        logic             tv;
        logic [CRC_W-1:0] tag;
    } core_st_t;

    core_st_t st_q, st_d;

    logic             take, cur_en, cur_refl, cur_inv, in_rng, use_b;
    logic [CRC_W-1:0] base, nxt_crc, fin;
    logic [CNT_W-1:0] cur_off;
    logic [7:0]       b_in;

    always_comb begin
        st_d     = st_q;
        st_d.tv  = 1'b0;

        take     = pkt_valid && (pkt_sop || st_q.active);
        cur_en   = pkt_sop ? pkt_tag_en     : st_q.en;
        cur_refl = pkt_sop ? cfg_in.reflect : st_q.reflect;
        cur_inv  = pkt_sop ? cfg_in.invert  : st_q.invert;
        base     = pkt_sop ? (cfg_in.reflect ? rev32(cfg_in.iv) : cfg_in.iv) : st_q.crc;
        cur_off  = pkt_sop ? '0 : st_q.off;

        lk_sel   = pkt_sop ? pkt_mask_sel : st_q.msel;
        lk_off   = cur_off[OFF_W-1:0];

        in_rng   = !cur_off[OFF_W];
        use_b    = take && cur_en && in_rng && lk_bit;
        b_in     = cur_refl ? rev8(pkt_data) : pkt_data;
        nxt_crc  = use_b ? crc_byte(base, b_in) : base;
        fin      = (cur_refl ? rev32(nxt_crc) : nxt_crc) ^ {CRC_W{cur_inv}};

        if (take) begin
            st_d.active  = 1'b1;
            st_d.en      = cur_en;
            st_d.reflect = cur_refl;
            st_d.invert  = cur_inv;
            st_d.msel    = lk_sel;
            st_d.crc     = nxt_crc;
            st_d.off     = cur_off[OFF_W] ? cur_off : cur_off + 1'b1;
            if (pkt_eop) begin
                st_d.active = 1'b0;
                st_d.tv     = 1'b1;
                st_d.tag    = fin;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tag_valid = st_q.tv;
    assign tag       = st_q.tag;

    // R9: an accepted end byte yields a tag in the next cycle.
    a_r9_tag_after_eop: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_valid && pkt_eop && (pkt_sop || st_q.active)) |=> tag_valid);

    // R9: a tag only follows a cycle carrying an end marker.
    a_r9_tag_cause: assert property (@(posedge clk) disable iff (!rst_n)
        tag_valid |-> $past(pkt_valid && pkt_eop));

    // R4: the offset counter never runs past the window edge.
    a_r4_off_bound: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.active |-> (st_q.off <= CNT_W'(1 << OFF_W)));

    // R5: with hashing off the running CRC does not move.
    a_r5_hash_off_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_valid && !pkt_sop && st_q.active && !st_q.en) |=> $stable(st_q.crc));

    // R10: a stray byte outside a packet produces no tag.
    a_r10_stray_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_valid && !pkt_sop && !st_q.active) |=> !tag_valid);

endmodule

// File: rtl/flowtag_crc_unit.sv
module flowtag_crc_unit
    import flowtag_pkg::*;
#(
    parameter int NUM_MASKS     = 4,
    parameter int REGS_PER_MASK = 16,
    parameter int NUM_IFS       = 2
) (
    input  logic                                       clk,
    input  logic                                       rst_n,
    input  logic                                       mreg_we,
    input  logic [$clog2(NUM_MASKS*REGS_PER_MASK)-1:0] mreg_idx,
    input  logic [7:0]                                 mreg_wdata,
    input  logic                                       mreg_or,
    input  logic                                       mask_clr,
    input  logic [$clog2(NUM_MASKS)-1:0]               mask_clr_sel,
    input  logic                                       crc_we,
    input  logic [((NUM_IFS > 1) ? $clog2(NUM_IFS) : 1)-1:0] crc_we_if,
    input  logic [31:0]                                crc_iv,
    input  logic                                       crc_reflect,
    input  logic                                       crc_invert,
    input  logic                                       pkt_valid,
    input  logic                                       pkt_sop,
    input  logic                                       pkt_eop,
    input  logic [7:0]                                 pkt_data,
    input  logic [$clog2(NUM_MASKS)-1:0]               pkt_mask_sel,
    input  logic [((NUM_IFS > 1) ? $clog2(NUM_IFS) : 1)-1:0] pkt_if,
    input  logic                                       pkt_tag_en,
    output logic                                       tag_valid,
    output logic [31:0]                                tag
);

    localparam int SEL_W = $clog2(NUM_MASKS);
    localparam int OFF_W = $clog2(REGS_PER_MASK) + 3;
    localparam int IF_W  = (NUM_IFS > 1) ? $clog2(NUM_IFS) : 1;

    crc_cfg_t         wr_cfg, sel_cfg;
    logic [SEL_W-1:0] lk_sel;
    logic [OFF_W-1:0] lk_off;
    logic             lk_bit;

    assign wr_cfg = '{iv: crc_iv, reflect: crc_reflect, invert: crc_invert};

    ftag_mask_bank #(
        .NUM_MASKS     (NUM_MASKS),
        .REGS_PER_MASK (REGS_PER_MASK)
    ) u_masks (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (mreg_we),
        .wr_idx  (mreg_idx),
        .wr_data (mreg_wdata),
        .wr_or   (mreg_or),
        .clr_en  (mask_clr),
        .clr_sel (mask_clr_sel),
        .lk_sel  (lk_sel),
        .lk_off  (lk_off),
        .lk_bit  (lk_bit)
    );

    ftag_crc_cfg #(
        .NUM_IFS (NUM_IFS),
        .IF_W    (IF_W)
    ) u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (crc_we),
        .wr_if  (crc_we_if),
        .wr_cfg (wr_cfg),
        .rd_if  (pkt_if),
        .rd_cfg (sel_cfg)
    );

    ftag_crc_core #(
        .SEL_W (SEL_W),
        .OFF_W (OFF_W)
    ) u_core (
        .clk          (clk),
        .rst_n        (rst_n),
        .pkt_valid    (pkt_valid),
        .pkt_sop      (pkt_sop),
        .pkt_eop      (pkt_eop),
        .pkt_data     (pkt_data),
        .pkt_mask_sel (pkt_mask_sel),
        .pkt_tag_en   (pkt_tag_en),
        .cfg_in       (sel_cfg),
        .lk_sel       (lk_sel),
        .lk_off       (lk_off),
        .lk_bit       (lk_bit),
        .tag_valid    (tag_valid),
        .tag          (tag)
    );

endmodule

// File: tb/flowtag_crc_unit_tb_top.sv
module flowtag_crc_unit_tb_top;

    localparam int NM = 4;
    localparam int MR = 16;
    localparam int NI = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mreg_we = 0, mreg_or = 0, mask_clr = 0, crc_we = 0;
    logic [5:0]  mreg_idx = '0;
    logic [7:0]  mreg_wdata = '0;
    logic [1:0]  mask_clr_sel = '0;
    logic [0:0]  crc_we_if = '0;
    logic [31:0] crc_iv = '0;
    logic        crc_reflect = 0, crc_invert = 0;
    logic        pkt_valid = 0, pkt_sop = 0, pkt_eop = 0, pkt_tag_en = 0;
    logic [7:0]  pkt_data = '0;
    logic [1:0]  pkt_mask_sel = '0;
    logic [0:0]  pkt_if = '0;
    logic        tag_valid;
    logic [31:0] tag;

    always #2 clk = ~clk;

    flowtag_crc_unit #(.NUM_MASKS(NM), .REGS_PER_MASK(MR), .NUM_IFS(NI)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .mreg_we(mreg_we), .mreg_idx(mreg_idx), .mreg_wdata(mreg_wdata), .mreg_or(mreg_or),
        .mask_clr(mask_clr), .mask_clr_sel(mask_clr_sel),
        .crc_we(crc_we), .crc_we_if(crc_we_if), .crc_iv(crc_iv),
        .crc_reflect(crc_reflect), .crc_invert(crc_invert),
        .pkt_valid(pkt_valid), .pkt_sop(pkt_sop), .pkt_eop(pkt_eop), .pkt_data(pkt_data),
        .pkt_mask_sel(pkt_mask_sel), .pkt_if(pkt_if), .pkt_tag_en(pkt_tag_en),
        .tag_valid(tag_valid), .tag(tag)
    );

    // ---------------- reference state ----------------
    logic [7:0]  m_reg [NM*MR];
    logic [31:0] m_iv  [NI];
    bit          m_rf  [NI];
    bit          m_inv [NI];

    int total = 0;
    int bad   = 0;
    int wd    = 0;
    bit done  = 0;

    typedef logic [7:0] bq_t[$];

    // expectation pipeline: set by driver, moved at the clock edge
    bit          nxt_v = 0, cur_v = 0;
    logic [31:0] nxt_tag = '0, cur_tag = '0;
    string       nxt_req = "R9", cur_req = "R9";
    logic [31:0] last_tag = '0;

    always @(posedge clk) begin
        cur_v   <= nxt_v;
        cur_tag <= nxt_tag;
        cur_req <= nxt_req;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] ref_tag(input bq_t pk, input int msel, input int ifn, input bit en);
        logic [31:0] c;
        c = m_iv[ifn];
        for (int i = 0; i < pk.size(); i++) begin
            if (en && i < 128 && m_reg[msel*16 + i/8][7 - (i % 8)]) begin
                if (m_rf[ifn]) begin
                    c = c ^ {24'h0, pk[i]};
                    for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 32'hEDB8_8320) : (c >> 1);
                end else begin
                    c = c ^ {pk[i], 24'h0};
                    for (int k = 0; k < 8; k++) c = c[31] ? ((c << 1) ^ 32'h04C1_1DB7) : (c << 1);
                end
            end
        end
        return m_inv[ifn] ? ~c : c;
    endfunction

    function automatic bq_t mk_pkt(input int n, input int seed);
        bq_t q;
        for (int i = 0; i < n; i++) q.push_back(8'((i * 37 + seed * 11 + 5) & 8'hFF));
        return q;
    endfunction

    // ---------------- cycle-by-cycle comparison ----------------
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk({cur_req, " tag_valid"}, {31'h0, tag_valid}, {31'h0, cur_v});
            if (cur_v) chk({cur_req, " tag"}, tag, cur_tag);
            if (tag_valid) last_tag = tag;
        end
    end

    // ---------------- drivers ----------------
    task automatic quiet();
        pkt_valid = 0; mreg_we = 0; mask_clr = 0; crc_we = 0; nxt_v = 0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            quiet();
        end
    endtask

    task automatic wr_mask(input int idx, input logic [7:0] d, input bit orv);
        @(posedge clk); #1;
        quiet();
        mreg_we = 1; mreg_idx = 6'(idx); mreg_wdata = d; mreg_or = orv;
        m_reg[idx] = orv ? (m_reg[idx] | d) : d;
    endtask

    task automatic clr_mask(input int m);
        @(posedge clk); #1;
        quiet();
        mask_clr = 1; mask_clr_sel = 2'(m);
        for (int i = 0; i < MR; i++) m_reg[m*MR + i] = 8'h00;
    endtask

    task automatic wr_crc(input int ifn, input logic [31:0] iv, input bit rf, input bit inv);
        @(posedge clk); #1;
        quiet();
        crc_we = 1; crc_we_if = 1'(ifn); crc_iv = iv; crc_reflect = rf; crc_invert = inv;
        m_iv[ifn] = iv; m_rf[ifn] = rf; m_inv[ifn] = inv;
    endtask

    task automatic send_pkt(input bq_t pk, input int msel, input int ifn, input bit en,
                            input int gap, input string req, input bit chg_cfg);
        logic [31:0] e;
        e = ref_tag(pk, msel, ifn, en);
        for (int i = 0; i < pk.size(); i++) begin
            @(posedge clk); #1;
            quiet();
            pkt_valid = 1; pkt_sop = (i == 0); pkt_eop = (i == pk.size() - 1);
            pkt_data = pk[i]; pkt_mask_sel = 2'(msel); pkt_if = 1'(ifn); pkt_tag_en = en;
            if (chg_cfg && i == 1) begin
                crc_we = 1; crc_we_if = 1'(ifn); crc_iv = ~m_iv[ifn];
                crc_reflect = ~m_rf[ifn]; crc_invert = ~m_inv[ifn];
                m_iv[ifn] = ~m_iv[ifn]; m_rf[ifn] = ~m_rf[ifn]; m_inv[ifn] = ~m_inv[ifn];
            end
            nxt_v = pkt_eop; nxt_tag = e; nxt_req = req;
            if (gap > 0 && i != pk.size() - 1) idle(gap);
        end
    endtask

    // bytes with no open packet (R10)
    task automatic stray(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            quiet();
            pkt_valid = 1; pkt_sop = 0; pkt_eop = (i == n - 1); pkt_data = 8'(i + 99);
        end
    endtask

    // an opened packet that never ends (R10)
    task automatic open_only(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            quiet();
            pkt_valid = 1; pkt_sop = (i == 0); pkt_eop = 0; pkt_data = 8'(i * 3 + 1);
            pkt_mask_sel = 2'd0; pkt_if = 1'd0; pkt_tag_en = 1;
        end
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    // ---------------- watchdog ----------------
    always @(posedge clk) begin
        wd++;
        if (wd > 150000 && !done) begin
            done = 1;
            total++; bad++;
            $display("FAIL R9 watchdog actual=%0d expected<=%0d", wd, 150000);
            summary();
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    initial begin
        bq_t p;
        for (int i = 0; i < NM*MR; i++) m_reg[i] = 8'h00;
        for (int i = 0; i < NI; i++) begin
            m_iv[i] = 32'hFFFF_FFFF; m_rf[i] = 1; m_inv[i] = 1;
        end

        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R9 reset tag_valid", {31'h0, tag_valid}, 32'h0);
        @(posedge clk); #1;
        rst_n = 1;

        // R7 R6 R8: check string through reset configuration of interface 0
        wr_mask(0, 8'hFF, 0);
        wr_mask(1, 8'hFF, 0);
        p = {8'h31, 8'h32, 8'h33, 8'h34, 8'h35, 8'h36, 8'h37, 8'h38, 8'h39};
        send_pkt(p, 0, 0, 1, 0, "R7", 0);
        idle(2);
        chk("R7 check value", last_tag, 32'hCBF4_3926);

        // R6: non-reflected, no inversion, scattered mask
        wr_crc(1, 32'h0000_0000, 0, 0);
        for (int i = 0; i < MR; i++) wr_mask(16 + i, 8'((i * 29 + 3) & 8'hFF), 0);
        send_pkt(mk_pkt(40, 1), 1, 1, 1, 0, "R6", 0);
        idle(1);
        send_pkt(mk_pkt(40, 2), 1, 1, 1, 0, "R6", 0);
        idle(1);

        // R1: MSB-first bit order
        clr_mask(2);
        wr_mask(32, 8'h80, 0);
        send_pkt(mk_pkt(8, 3), 2, 1, 1, 0, "R1", 0);
        idle(1);
        wr_mask(32, 8'h01, 0);
        send_pkt(mk_pkt(8, 3), 2, 1, 1, 0, "R1", 0);
        idle(1);
        wr_mask(33, 8'h40, 0);
        send_pkt(mk_pkt(16, 4), 2, 0, 1, 0, "R1", 0);
        idle(1);

        // R2: replace vs OR
        clr_mask(2);
        wr_mask(34, 8'h0F, 0);
        wr_mask(34, 8'hF0, 1);
        send_pkt(mk_pkt(24, 5), 2, 1, 1, 0, "R2", 0);
        idle(1);
        wr_mask(34, 8'h03, 0);
        send_pkt(mk_pkt(24, 5), 2, 1, 1, 0, "R2", 0);
        idle(1);

        // R3: clear leaves no selected byte; reflect-on empty gives the IV
        for (int i = 0; i < MR; i++) wr_mask(48 + i, 8'hFF, 0);
        clr_mask(3);
        wr_crc(1, 32'h1234_5678, 1, 0);
        send_pkt(mk_pkt(30, 6), 3, 1, 1, 0, "R3", 0);
        idle(2);
        chk("R3 empty tag", last_tag, 32'h1234_5678);

        // R4: window edge and short packet
        for (int i = 0; i < MR; i++) wr_mask(48 + i, 8'hFF, 0);
        send_pkt(mk_pkt(200, 7), 3, 0, 1, 0, "R4", 0);
        idle(2);
        p = mk_pkt(128, 7);
        chk("R4 long equals 128-byte prefix", last_tag, ref_tag(p, 3, 0, 1));
        send_pkt(mk_pkt(5, 8), 3, 1, 1, 0, "R4", 0);
        idle(1);

        // R5: hashing off
        send_pkt(mk_pkt(20, 9), 3, 0, 0, 0, "R5", 0);
        idle(2);
        chk("R5 hash off", last_tag, 32'h0000_0000);

        // R8: invert on versus off for the same data
        wr_crc(1, 32'hA5A5_0F0F, 0, 1);
        send_pkt(mk_pkt(12, 10), 3, 1, 1, 0, "R8", 0);
        idle(1);

        // R9 R10: one-byte packet, back-to-back, gaps
        send_pkt(mk_pkt(1, 11), 3, 1, 1, 0, "R10", 0);
        send_pkt(mk_pkt(6, 12), 1, 0, 1, 0, "R9", 0);
        send_pkt(mk_pkt(9, 13), 3, 1, 1, 2, "R10", 0);
        idle(2);

        // R10: stray bytes and a discarded open packet
        stray(3);
        idle(1);
        open_only(4);
        send_pkt(mk_pkt(10, 14), 0, 0, 1, 0, "R10", 0);
        idle(2);

        // R11: configuration rewritten mid-packet does not touch it
        wr_crc(1, 32'h0BAD_F00D, 0, 0);
        send_pkt(mk_pkt(15, 15), 3, 1, 1, 0, "R11", 1);
        idle(1);
        send_pkt(mk_pkt(15, 15), 3, 1, 1, 0, "R11", 0);
        idle(3);

        done = 1;
        summary();
        $finish;
    end

endmodule